// File: doc/BRIEF.md
# Conversion Auto-Start Event Selector

This block starts analog conversions without software involvement. Up to eight single-bit event flags, each raised by another peripheral on the chip, arrive on a flag vector. A 3-bit field in a small control register picks one of them. While the auto-start enable input is high, each rising edge of the picked flag produces a start request to the converter. That request is a one-clock pulse.

Edges are found after the selection multiplexer. The multiplexer output is compared with its own value from one clock earlier. A change of selection therefore counts like a change of the flag itself. Moving the field from a source whose flag is low to one whose flag is high starts a conversion. Moving it between two high sources, or from high to low, does not.

The 8-bit control register also holds one spare read/write control bit, which drives an output of its own. The remaining bits are reserved. They ignore written data and always read back as zero.

Top module: `adc_trig_sel`

## Requirements
- R1: After reset (asynchronous, active-low `rst_n`), the control register reads 0x00, `aux_ctl` is 0 and `start_conv` is 0.
- R2: A write (`wr_en` high at a clock edge) stores `wr_data[2:0]` as the source select and `wr_data[6]` as the spare control bit. From the next cycle, `rd_data[2:0]` and `rd_data[6]` show the stored values and `aux_ctl` equals bit 6.
- R3: Register bits 7, 5, 4 and 3 ignore written values and always read back as 0.
- R4: With `trig_en` high, a 0-to-1 change of `flags[sel]`, where sel is the value in `rd_data[2:0]`, makes `start_conv` high for exactly the one cycle after the clock edge that first samples the flag high.
- R5: A selected flag that stays high produces no further pulses. A falling edge produces no pulse.
- R6: While `trig_en` is low, no pulse is produced for any flag activity or selection change.
- R7: Activity on flags that are not selected produces no pulse.
- R8: Writing a new select value while the old selected flag is 0 and the newly selected flag is 1 produces one pulse, one cycle after the new select value takes effect. Switching between two sources whose flags are both 1 produces no pulse.
- R9: Raising `trig_en` while the selected flag is already high produces no pulse, because the flag level is not an edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data: [2:0] select, [6] spare bit |
| rd_data | output | 8 | Control register read-back; bits 7 and 5:3 are always 0 |
| aux_ctl | output | 1 | Spare control bit (register bit 6) |
| trig_en | input | 1 | Auto-start enable |
| flags | input | 8 | Event flag inputs, one per source |
| start_conv | output | 1 | One-clock start-conversion pulse |

## Verification
The edge detector holds only a little state: the previous multiplexer value. If that register is wrong, a pulse is missing or an extra one appears in the very next cycle after the flag or the selection changes. The bench therefore compares `start_conv` against a reference every cycle. A wrong select register shows at `rd_data` one cycle after the write. It also shows as pulses tied to the wrong flag, which the tests expose by toggling unselected flags. Selection switches between high and low sources exercise the path where the multiplexer, not the flag, makes the edge.

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int NSRC = 8,
  parameter int REGW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [REGW-1:0] wr_data,
  output logic [REGW-1:0] rd_data,
  output logic            aux_ctl,
  input  logic            trig_en,
  input  logic [NSRC-1:0] flags,
  output logic            start_conv
);
  localparam int SELW    = $clog2(NSRC);
  localparam int AUX_POS = 6;

  logic [SELW-1:0] sel_q;
  logic            aux_q;
  logic            mux_now;
  logic            mux_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
      aux_q <= 1'b0;
    end else if (wr_en) begin
      sel_q <= wr_data[SELW-1:0];
      aux_q <= wr_data[AUX_POS];
    end
  end

  assign mux_now = flags[sel_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mux_prev   <= 1'b0;
      start_conv <= 1'b0;
    end else begin
      mux_prev   <= mux_now;
      start_conv <= trig_en & mux_now & ~mux_prev;
    end
  end

  always_comb begin
    rd_data                = '0;
    rd_data[SELW-1:0]      = sel_q;
    rd_data[AUX_POS]       = aux_q;
  end

  assign aux_ctl = aux_q;
endmodule

module adc_trig_sel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       aux_ctl,
  input logic       trig_en,
  input logic [7:0] flags,
  input logic       start_conv
);
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rd_data[2:0] == $past(wr_data[2:0]) && rd_data[6] == $past(wr_data[6])));

  a_r2_aux_matches: assert property (@(posedge clk) disable iff (!rst_n)
    aux_ctl == rd_data[6]);

  a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[7] == 1'b0 && rd_data[5:3] == 3'b000);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_conv |=> !start_conv);

  a_r6_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_conv) |-> $past(trig_en));

  a_r4_selected_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_conv) |-> $past(flags[rd_data[2:0]]));
endmodule

bind adc_trig_sel adc_trig_sel_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .aux_ctl(aux_ctl), .trig_en(trig_en),
  .flags(flags), .start_conv(start_conv)
);

// File: tb/adc_trig_sel_test.sv
module adc_trig_sel_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       aux_ctl;
  logic       trig_en = 1'b0;
  logic [7:0] flags = '0;
  logic       start_conv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic exp; string tag; } item_t;
  item_t q[$];

  logic [2:0] m_sel = '0;
  logic       m_prev = 1'b0;
  string      cur_tag = "R1";

  adc_trig_sel uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .aux_ctl(aux_ctl), .trig_en(trig_en),
    .flags(flags), .start_conv(start_conv)
  );

  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one cycle: inputs set after negedge, expected pulse queued
  task automatic step(input logic en, input logic [7:0] f, input logic we, input logic [7:0] wd);
    item_t it;
    @(negedge clk);
    trig_en = en; flags = f; wr_en = we; wr_data = wd;
    it.exp = en & f[m_sel] & ~m_prev;
    it.tag = cur_tag;
    m_prev = f[m_sel];
    if (we) m_sel = wd[2:0];
    #1 q.push_back(it);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check(it.tag, {7'd0, start_conv}, {7'd0, it.exp});
    end
  end

  initial begin
    #2;
    check("R1 reg", rd_data, 8'h00);
    check("R1 start", {7'd0, start_conv}, 8'h00);
    check("R1 aux", {7'd0, aux_ctl}, 8'h00);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    cur_tag = "R2";
    step(0, 8'h00, 1, 8'hFF);
    step(0, 8'h00, 0, 8'h00);
    @(negedge clk); #2;
    check("R2/R3 readback 0xFF", rd_data, 8'h47);
    check("R2 aux", {7'd0, aux_ctl}, 8'h01);
    cur_tag = "R3";
    step(0, 8'h00, 1, 8'hB8);
    step(0, 8'h00, 0, 8'h00);
    @(negedge clk); #2;
    check("R3 reserved ignored", rd_data, 8'h00);

    cur_tag = "R2";
    step(0, 8'h00, 1, 8'h03);
    step(0, 8'h00, 0, 8'h00);
    @(negedge clk); #2;
    check("R2 select 3", rd_data, 8'h03);

    cur_tag = "R4";
    step(1, 8'h00, 0, 0);
    step(1, 8'h08, 0, 0);
    cur_tag = "R5";
    repeat (4) step(1, 8'h08, 0, 0);
    step(1, 8'h00, 0, 0);
    step(1, 8'h00, 0, 0);
    cur_tag = "R4";
    step(1, 8'h08, 0, 0);
    step(1, 8'h00, 0, 0);
    step(1, 8'h08, 0, 0);

    cur_tag = "R7";
    step(1, 8'h08, 0, 0);
    step(1, 8'hF7, 0, 0);
    step(1, 8'h00, 0, 0);
    step(1, 8'hF7, 0, 0);
    step(1, 8'h00, 0, 0);

    cur_tag = "R6";
    step(0, 8'h08, 0, 0);
    step(0, 8'h00, 0, 0);
    step(0, 8'h08, 0, 0);
    step(0, 8'h21, 1, 8'h05);
    step(0, 8'h21, 0, 0);
    step(0, 8'h00, 0, 0);

    cur_tag = "R9";
    step(0, 8'h20, 0, 0);
    step(1, 8'h20, 0, 0);
    step(1, 8'h20, 0, 0);

    cur_tag = "R8";
    step(1, 8'h00, 1, 8'h01);
    step(1, 8'h00, 0, 0);
    step(1, 8'h80, 0, 0);
    step(1, 8'h80, 1, 8'h07);
    step(1, 8'h80, 0, 0);
    step(1, 8'h80, 0, 0);
    step(1, 8'h81, 1, 8'h00);
    step(1, 8'h81, 0, 0);
    step(1, 8'h01, 1, 8'h02);
    step(1, 8'h01, 0, 0);
    step(1, 8'h01, 0, 0);

    step(0, 8'h00, 0, 0);
    step(0, 8'h00, 0, 0);
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule